// File: doc/BRIEF.md
# Framed Serial Four-Bit Pattern Detector

This block watches a serial bit stream and cuts it into consecutive groups of four accepted bits that do not overlap. On the cycle that carries the last bit of a group, it raises `match` if that group, read in arrival order with the first bit on the left, is `0110` or `1010`. Once a group's fourth bit has been taken, the machine goes back to its start state, whether or not the group matched. The next accepted bit then opens a new group.

The decision is Mealy: `match` depends on the stored state and on the bit presented in the same cycle, so the result appears together with the fourth bit and needs no extra cycle. The control is a minimized seven-state machine held in a three-bit register. Bits arrive with a valid qualifier and there is no ready signal, because the block accepts a bit on every cycle where `bit_valid` is high and never applies back-pressure. Cycles with `bit_valid` low are gaps in the stream and do not count toward a group. The sample stream `0010 0110 1100 1010 0011` gives `match` only on the last bit of the second and fourth groups.

Top module: `quad_pattern_detector`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine goes to its start state, so the next accepted bit is the first bit of a group. `match` is 0 in every cycle where `rst` is high.
- R2: `match` can be 1 only in a cycle where `bit_valid` is high and the bit presented is the fourth accepted bit of the current group.
- R3: On the fourth accepted bit, `match` is 1 exactly when the group, written first-arrived bit leftmost, equals `0110` or `1010`. For the other 14 four-bit values it is 0.
- R4: Groups do not overlap. After the fourth accepted bit, the next accepted bit always starts a new group, whether or not the group matched.
- R5: In a cycle where `bit_valid` is low, `bit_data` is ignored, `match` is 0 and the group position does not change.
- R6: `match` is valid in the same cycle as the fourth bit it reports, with no added latency.
- R7: The accepted stream `0010 0110 1100 1010 0011` gives `match` = 1 only on the 8th and 16th bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the start of a group |
| bit_valid | input | 1 | High when `bit_data` carries a stream bit this cycle |
| bit_data | input | 1 | Serial data bit |
| match | output | 1 | High on the fourth bit of a group equal to 0110 or 1010 |

## Verification
The assertions check on every cycle that `match` fires only on a counted fourth valid bit and that this bit is 0. They also check that the machine is back in its start state after each fourth bit, that it holds its state across gaps, and that it never reaches the unused state code. Only the bench scenarios can show that the match decision is right for every group value. The same holds for a reset in the middle of a group, for gap cycles carrying data that would otherwise complete a pattern, and for the sample stream. A long random stream with gaps is compared against a modulo-4 counter and shift-register model.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int STATE_W = 3;

  // Minimized state set: seven states, one three-bit code unused.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0, // start of a group
    ST_P0    = 3'd1, // first bit was 0
    ST_P1    = 3'd2, // first bit was 1
    ST_LIVE2 = 3'd3, // prefix 01 or 10, still able to match
    ST_DEAD2 = 3'd4, // two bits seen, cannot match
    ST_LIVE3 = 3'd5, // prefix 011 or 101, a final 0 matches
    ST_DEAD3 = 3'd6  // three bits seen, cannot match
  } qpd_state_e;

  localparam logic [STATE_W-1:0] STATE_UNUSED = 3'd7;
endpackage

// File: rtl/qpd_step_logic.sv
module qpd_step_logic
  import qpd_pkg::*;
(
  input  qpd_state_e cur,
  input  logic       take,
  input  logic       din,
  output qpd_state_e nxt,
  output logic       hit
);
  always_comb begin
    nxt = cur;
    hit = 1'b0;
    if (take) begin
      unique case (cur)
        ST_IDLE:  nxt = din ? ST_P1 : ST_P0;
        ST_P0:    nxt = din ? ST_LIVE2 : ST_DEAD2;
        ST_P1:    nxt = din ? ST_DEAD2 : ST_LIVE2;
        ST_LIVE2: nxt = din ? ST_LIVE3 : ST_DEAD3;
        ST_DEAD2: nxt = ST_DEAD3;
        ST_LIVE3: begin
          nxt = ST_IDLE;
          hit = ~din;
        end
        ST_DEAD3: nxt = ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qpd_state_reg.sv
module qpd_state_reg #(
  parameter int                 W       = 3,
  parameter logic [W-1:0]       RST_VAL = '0,
  parameter logic [W-1:0]       BAD_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= d;
  end

  AST_HOLD_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R5

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    q != BAD_VAL); // R4
endmodule

// File: rtl/quad_pattern_detector.sv
module quad_pattern_detector
  import qpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_data,
  output logic match
);
  localparam int GROUP_LEN = 4;
  localparam int POS_W     = $clog2(GROUP_LEN);

  qpd_state_e             state_q;
  qpd_state_e             state_d;
  logic [STATE_W-1:0]     state_raw;
  logic                   hit;

  qpd_step_logic u_step (
    .cur  (state_q),
    .take (bit_valid),
    .din  (bit_data),
    .nxt  (state_d),
    .hit  (hit)
  );

  qpd_state_reg #(
    .W       (STATE_W),
    .RST_VAL (ST_IDLE),
    .BAD_VAL (STATE_UNUSED)
  ) u_state (
    .clk (clk),
    .rst (rst),
    .en  (bit_valid),
    .d   (state_d),
    .q   (state_raw)
  );

  assign state_q = qpd_state_e'(state_raw);
  assign match   = hit & ~rst;

  // Independent position tracker used only by the checks below.
  logic [POS_W-1:0] pos_q;
  always_ff @(posedge clk) begin
    if (rst)            pos_q <= '0;
    else if (bit_valid) pos_q <= pos_q + 1'b1;
  end

  AST_MATCH_ON_FOURTH: assert property (@(posedge clk) disable iff (rst)
    match |-> (bit_valid && pos_q == POS_W'(GROUP_LEN - 1))); // R2

  AST_MATCH_LAST_ZERO: assert property (@(posedge clk) disable iff (rst)
    match |-> !bit_data); // R3

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && pos_q == POS_W'(GROUP_LEN - 1)) |=> (state_q == ST_IDLE)); // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !match); // R1
endmodule

// File: tb/sim_quad_pattern_detector.sv
`timescale 1ns/1ps
module sim_quad_pattern_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic match;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model
  int       ref_pos = 0;
  logic [2:0] ref_hist = '0;

  always #2.5 clk = ~clk;

  quad_pattern_detector u0 (
    .clk (clk), .rst (rst), .bit_valid (bit_valid),
    .bit_data (bit_data), .match (match)
  );

  function automatic logic expect_match(int pos, logic [2:0] hist, logic v, logic d);
    logic [3:0] grp;
    grp = {hist, d};
    return v && pos == 3 && (grp == 4'b0110 || grp == 4'b1010);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1'b1;
      bit_valid = 1'b1;
      bit_data = 1'b0;
      #1;
      check(req, match, 1'b0);
    end
    ref_pos = 0;
    ref_hist = '0;
    @(negedge clk);
    rst = 1'b0;
    bit_valid = 1'b0;
  endtask

  task automatic send(logic v, logic d, string req);
    logic e;
    @(negedge clk);
    bit_valid = v;
    bit_data = d;
    #1;
    e = expect_match(ref_pos, ref_hist, v, d);
    check(req, match, e);
    if (v) begin
      ref_hist = {ref_hist[1:0], d};
      ref_pos = (ref_pos + 1) % 4;
    end
  endtask

  task automatic send_group(logic [3:0] g, string req);
    for (int i = 3; i >= 0; i--) send(1'b1, g[i], req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] sample;
    logic [19:0] sample_out;
    process::self().srandom(32'd1234);

    // R1: reset state, match quiet during reset
    do_reset(3, "R1");
    send(1'b0, 1'b0, "R5");

    // R7: the sample stream, checked bit by bit against fixed expectations
    sample     = 20'b0010_0110_1100_1010_0011;
    sample_out = 20'b0000_0001_0000_0001_0000;
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data = sample[i];
      #1;
      check("R7", match, sample_out[i]);
      ref_hist = {ref_hist[1:0], sample[i]};
      ref_pos = (ref_pos + 1) % 4;
    end

    // R3: every four-bit value as a group
    for (int g = 0; g < 16; g++) send_group(4'(g), "R3");

    // R5: gaps with data that would complete a match are ignored
    send(1'b1, 1'b0, "R5");
    send(1'b1, 1'b1, "R5");
    send(1'b1, 1'b1, "R5");
    send(1'b0, 1'b0, "R5");
    send(1'b0, 1'b0, "R5");
    send(1'b1, 1'b0, "R6");

    // R4: a matching group straight after a matching group, and a shifted pattern
    send_group(4'b1010, "R4");
    send_group(4'b0110, "R4");
    send_group(4'b0011, "R4");
    send_group(4'b0100, "R4");

    // R1: reset in the middle of a group restarts framing
    send(1'b1, 1'b1, "R1");
    send(1'b1, 1'b0, "R1");
    do_reset(1, "R1");
    send_group(4'b0110, "R1");

    // R2/R4/R5: random stream with gaps against the counter model
    for (int i = 0; i < 3000; i++) begin
      send(($urandom % 10) < 7, 1'($urandom), "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule